// File: doc/BRIEF.md
# Block Copy Sequencer

This block carries out the byte-copy instructions of an 8-bit processor as one hardware operation. It is given a source pointer, a destination pointer, a 16-bit byte count, the accumulator and the incoming flag byte. On each iteration it fetches one byte from the source address and stores it at the destination address. It then moves both pointers one step, lowers the count by one and forms the new flag byte. The engine can perform a single step, or repeat steps until the count runs out, and the pointers can move up or down through memory.

Alongside the data movement the engine totals the instruction cycles the processor would spend. A step costs a fixed base amount. In repeat mode, every iteration that is not the last costs a fixed penalty on top. When the operation completes, the final pointers, count, flags and cycle total are left on the outputs and a one-cycle completion pulse is raised. The memory side is a single synchronous port: read data arrives one clock after the read request.

Top module: `blkcpy_engine`

## Requirements
- R1: A start seen while idle latches the operands. The next cycle raises mem_re with mem_addr equal to the source pointer. The cycle after that raises mem_we with mem_addr equal to the destination pointer, and mem_wdata carries the byte the memory returned.
- R2: After each step, both pointers grow by one when dec_mode is 0 and shrink by one when dec_mode is 1. Pointer arithmetic wraps modulo 65536.
- R3: Each step lowers the count by one. A count of 0 wraps to 65535.
- R4: In flags_out, bits 7, 6 and 0 are copied from flags_in, and bits 4 and 1 are zero.
- R5: Bit 2 of flags_out is 1 exactly when the count left after the last decrement is nonzero. The rule is the same in both modes.
- R6: Let n be the last copied byte plus the accumulator, modulo 256. Bit 3 of flags_out equals bit 3 of n, and bit 5 of flags_out equals bit 1 of n.
- R7: With rep_mode at 0, exactly one byte is copied and cycles_out reads 16.
- R8: With rep_mode at 1, iterations continue until the count reaches zero. For k iterations, cycles_out reads 16*k + 5*(k-1). A starting count of 0 gives 65536 iterations.
- R9: done is a pulse one cycle long. It appears only after the final iteration, busy is high from acceptance until that point, and the outputs hold their values until the next start.
- R10: A start asserted while busy is high has no effect on the running operation or on its results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin an operation when idle |
| rep_mode | input | 1 | 1 = repeat until count is zero |
| dec_mode | input | 1 | 1 = pointers move downward |
| src_in | input | 16 | Starting source pointer |
| dst_in | input | 16 | Starting destination pointer |
| cnt_in | input | 16 | Starting byte count |
| acc_in | input | 8 | Accumulator value |
| flags_in | input | 8 | Incoming flag byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_re | output | 1 | Memory read request |
| mem_we | output | 1 | Memory write request |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after mem_re |
| src_out | output | 16 | Final source pointer |
| dst_out | output | 16 | Final destination pointer |
| cnt_out | output | 16 | Final count |
| flags_out | output | 8 | Resulting flag byte |
| cycles_out | output | 32 | Total instruction cycles |

## Verification
The hardest case to reach is a repeat operation that starts from a zero count. It has to sweep the entire 64 KiB space, carry both pointers through the wrap point and stop with the count back at zero. The stimulus launches such a run directly. A write monitor then confirms every address and data pair, and the final cycle total is compared with the closed-form value. A second hard case is a start request that arrives mid-operation. It is reached by pulsing start with different operands while a repeat copy is running, and then checking that the results match the first operands.

// File: rtl/blkcpy_pkg.sv
package blkcpy_pkg;
   typedef enum logic [1:0] {
      BC_IDLE  = 2'd0,
      BC_READ  = 2'd1,
      BC_WRITE = 2'd2
   } bc_state_e;

   localparam int FB_SIGN  = 7;
   localparam int FB_ZERO  = 6;
   localparam int FB_UND5  = 5;
   localparam int FB_HALF  = 4;
   localparam int FB_UND3  = 3;
   localparam int FB_PV    = 2;
   localparam int FB_SUB   = 1;
   localparam int FB_CARRY = 0;
endpackage

// File: rtl/blkcpy_ptr_step.sv
module blkcpy_ptr_step #(
   parameter int AW = 16
) (
   input  logic [AW-1:0] ptr,
   input  logic          dec,
   output logic [AW-1:0] nxt
);
   localparam logic [AW-1:0] ONE = AW'(1);

   generate
      if (AW < 2) begin : g_bad_aw
         $error("blkcpy_ptr_step: AW must be at least 2");
      end
   endgenerate

   always_comb begin
      if (dec) nxt = ptr - ONE;
      else     nxt = ptr + ONE;
   end
endmodule

// File: rtl/blkcpy_flag_gen.sv
module blkcpy_flag_gen
   import blkcpy_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic [DW-1:0] f_in,
   input  logic [DW-1:0] data,
   input  logic [DW-1:0] acc,
   input  logic          more,
   output logic [DW-1:0] f_out
);
   logic [DW-1:0] sum;

   generate
      if (DW != 8) begin : g_bad_dw
         $error("blkcpy_flag_gen: flag layout needs DW of 8");
      end
   endgenerate

   assign sum = data + acc;

   always_comb begin
      f_out           = '0;
      f_out[FB_SIGN]  = f_in[FB_SIGN];
      f_out[FB_ZERO]  = f_in[FB_ZERO];
      f_out[FB_CARRY] = f_in[FB_CARRY];
      f_out[FB_UND3]  = sum[3];
      f_out[FB_UND5]  = sum[1];
      f_out[FB_PV]    = more;
   end
endmodule

// File: rtl/blkcpy_cycle_acc.sv
module blkcpy_cycle_acc #(
   parameter int CYC_W     = 32,
   parameter int STEP_COST = 16,
   parameter int REP_COST  = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             add_en,
   input  logic             extra,
   output logic [CYC_W-1:0] total
);
   localparam logic [CYC_W-1:0] BASE = CYC_W'(STEP_COST);
   localparam logic [CYC_W-1:0] PEN  = CYC_W'(REP_COST);

   logic [CYC_W-1:0] inc;

   generate
      if (CYC_W < 8) begin : g_bad_w
         $error("blkcpy_cycle_acc: CYC_W too narrow");
      end
      if (REP_COST == 0) begin : g_no_pen
         assign inc = BASE;
      end else begin : g_pen
         assign inc = extra ? (BASE + PEN) : BASE;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      total <= '0;
      else if (clr)    total <= '0;
      else if (add_en) total <= total + inc;
   end

   // R7
   step_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (add_en && !clr) |=> (total >= BASE));
endmodule

// File: rtl/blkcpy_engine.sv
module blkcpy_engine
   import blkcpy_pkg::*;
#(
   parameter int AW        = 16,
   parameter int DW        = 8,
   parameter int CW        = 16,
   parameter int CYC_W     = 32,
   parameter int STEP_COST = 16,
   parameter int REP_COST  = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             rep_mode,
   input  logic             dec_mode,
   input  logic [AW-1:0]    src_in,
   input  logic [AW-1:0]    dst_in,
   input  logic [CW-1:0]    cnt_in,
   input  logic [DW-1:0]    acc_in,
   input  logic [DW-1:0]    flags_in,
   output logic             busy,
   output logic             done,
   output logic             mem_re,
   output logic             mem_we,
   output logic [AW-1:0]    mem_addr,
   output logic [DW-1:0]    mem_wdata,
   input  logic [DW-1:0]    mem_rdata,
   output logic [AW-1:0]    src_out,
   output logic [AW-1:0]    dst_out,
   output logic [CW-1:0]    cnt_out,
   output logic [DW-1:0]    flags_out,
   output logic [CYC_W-1:0] cycles_out
);
   localparam logic [CW-1:0] CNT_ONE = CW'(1);

   generate
      if (CW < 2) begin : g_bad_cw
         $error("blkcpy_engine: CW must be at least 2");
      end
      if (STEP_COST < 1) begin : g_bad_cost
         $error("blkcpy_engine: STEP_COST must be positive");
      end
   endgenerate

   bc_state_e     state_q;
   logic [AW-1:0] src_q, dst_q, src_nxt, dst_nxt;
   logic [CW-1:0] cnt_q, cnt_nxt;
   logic [DW-1:0] acc_q, fin_q, flg_q, flg_nxt;
   logic          rep_q, dec_q, done_q;
   logic          accept, stepping, more, last;

   assign accept   = start && (state_q == BC_IDLE);
   assign stepping = (state_q == BC_WRITE);
   assign cnt_nxt  = cnt_q - CNT_ONE;
   assign more     = (cnt_nxt != '0);
   assign last     = !rep_q || !more;

   blkcpy_ptr_step #(.AW(AW)) u_src_step (
      .ptr (src_q),
      .dec (dec_q),
      .nxt (src_nxt)
   );

   blkcpy_ptr_step #(.AW(AW)) u_dst_step (
      .ptr (dst_q),
      .dec (dec_q),
      .nxt (dst_nxt)
   );

   blkcpy_flag_gen #(.DW(DW)) u_flags (
      .f_in  (fin_q),
      .data  (mem_rdata),
      .acc   (acc_q),
      .more  (more),
      .f_out (flg_nxt)
   );

   blkcpy_cycle_acc #(
      .CYC_W     (CYC_W),
      .STEP_COST (STEP_COST),
      .REP_COST  (REP_COST)
   ) u_cycles (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (accept),
      .add_en (stepping),
      .extra  (rep_q && !last),
      .total  (cycles_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= BC_IDLE;
         src_q   <= '0;
         dst_q   <= '0;
         cnt_q   <= '0;
         acc_q   <= '0;
         fin_q   <= '0;
         flg_q   <= '0;
         rep_q   <= 1'b0;
         dec_q   <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            BC_IDLE: begin
               if (start) begin
                  src_q   <= src_in;
                  dst_q   <= dst_in;
                  cnt_q   <= cnt_in;
                  acc_q   <= acc_in;
                  fin_q   <= flags_in;
                  rep_q   <= rep_mode;
                  dec_q   <= dec_mode;
                  state_q <= BC_READ;
               end
            end
            BC_READ: begin
               state_q <= BC_WRITE;
            end
            BC_WRITE: begin
               src_q <= src_nxt;
               dst_q <= dst_nxt;
               cnt_q <= cnt_nxt;
               flg_q <= flg_nxt;
               if (last) begin
                  state_q <= BC_IDLE;
                  done_q  <= 1'b1;
               end else begin
                  state_q <= BC_READ;
               end
            end
            default: state_q <= BC_IDLE;
         endcase
      end
   end

   assign busy      = (state_q != BC_IDLE);
   assign done      = done_q;
   assign mem_re    = (state_q == BC_READ);
   assign mem_we    = stepping;
   assign mem_addr  = (state_q == BC_READ) ? src_q : dst_q;
   assign mem_wdata = mem_rdata;
   assign src_out   = src_q;
   assign dst_out   = dst_q;
   assign cnt_out   = cnt_q;
   assign flags_out = flg_q;

   // R1
   port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_re && mem_we));

   // R1
   read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re |=> mem_we);

   // R2
   inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && !dec_q) |=> (src_out == AW'($past(src_out) + 1'b1)));

   // R2
   dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && dec_q) |=> (dst_out == AW'($past(dst_out) - 1'b1)));

   // R3
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> (cnt_out == CW'($past(cnt_out) - 1'b1)));

   // R4
   clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!flags_out[FB_HALF] && !flags_out[FB_SUB]));

   // R5
   pv_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (flags_out[FB_PV] == (cnt_out != '0)));

   // R7
   single_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !rep_q) |-> (cycles_out == CYC_W'(STEP_COST)));

   // R8
   repeat_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && rep_q) |-> (cnt_out == '0));

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R10
   hold_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(acc_q));
endmodule

// File: tb/tb_blkcpy_engine.sv
module tb_blkcpy_engine;
   typedef struct packed {
      logic        rep;
      logic        dec;
      logic [15:0] src;
      logic [15:0] dst;
      logic [15:0] cnt;
      logic [7:0]  acc;
      logic [7:0]  fl;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 1'b0, 16'h1000, 16'h2000, 16'h0003, 8'h10, 8'hFF},
      '{1'b0, 1'b1, 16'h0000, 16'hFFFF, 16'h0001, 8'h00, 8'h00},
      '{1'b0, 1'b0, 16'h4321, 16'h8765, 16'h0000, 8'hF3, 8'h41},
      '{1'b1, 1'b0, 16'h0300, 16'h0400, 16'h0005, 8'h22, 8'h81},
      '{1'b1, 1'b1, 16'h0002, 16'h0010, 16'h0004, 8'h07, 8'hC0},
      '{1'b1, 1'b0, 16'hABCD, 16'h1234, 16'h0001, 8'h99, 8'h01},
      '{1'b0, 1'b0, 16'hFFFF, 16'hFFFF, 16'h0009, 8'h5A, 8'h16}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0, rep_mode = 1'b0, dec_mode = 1'b0;
   logic [15:0] src_in = '0, dst_in = '0, cnt_in = '0;
   logic [7:0]  acc_in = '0, flags_in = '0;
   logic        busy, done, mem_re, mem_we;
   logic [15:0] mem_addr, src_out, dst_out, cnt_out;
   logic [7:0]  mem_wdata, flags_out;
   logic [7:0]  mem_rdata = '0;
   logic [31:0] cycles_out;

   int          n_chk = 0, n_fail = 0;
   int          n_wr = 0, n_wrerr = 0;
   logic [15:0] last_ra = '0, exp_wa = '0;
   logic        exp_dec = 1'b0;

   always #2.5 clk = ~clk;

   blkcpy_engine dut (
      .clk(clk), .rst_n(rst_n), .start(start), .rep_mode(rep_mode),
      .dec_mode(dec_mode), .src_in(src_in), .dst_in(dst_in), .cnt_in(cnt_in),
      .acc_in(acc_in), .flags_in(flags_in), .busy(busy), .done(done),
      .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .src_out(src_out),
      .dst_out(dst_out), .cnt_out(cnt_out), .flags_out(flags_out),
      .cycles_out(cycles_out)
   );

   function automatic logic [7:0] mem_byte(input logic [15:0] a);
      return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
   endfunction

   always @(posedge clk) begin
      if (mem_re) mem_rdata <= mem_byte(mem_addr);
   end

   always @(posedge clk) begin
      if (mem_re) last_ra = mem_addr;
      if (mem_we) begin
         n_wr = n_wr + 1;
         if (mem_wdata !== mem_byte(last_ra) || mem_addr !== exp_wa)
            n_wrerr = n_wrerr + 1;
         exp_wa = exp_dec ? exp_wa - 16'd1 : exp_wa + 16'd1;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic launch(input vec_t v);
      @(negedge clk);
      n_wr = 0; n_wrerr = 0;
      exp_wa = v.dst; exp_dec = v.dec;
      rep_mode = v.rep; dec_mode = v.dec;
      src_in = v.src; dst_in = v.dst; cnt_in = v.cnt;
      acc_in = v.acc; flags_in = v.fl;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done(output bit ok);
      ok = 1'b0;
      for (int i = 0; i < 140000; i++) begin
         if (done) begin ok = 1'b1; break; end
         @(negedge clk);
      end
      if (!ok) begin
         n_chk++; n_fail++;
         $display("FAIL R9 watchdog actual=no_done expected=done");
      end
   endtask

   task automatic expect_result(input vec_t v);
      int          k;
      logic [15:0] s, d, c, lr;
      logic [7:0]  n, f;
      logic [31:0] cyc;
      k  = v.rep ? ((v.cnt == 16'd0) ? 65536 : int'(v.cnt)) : 1;
      s  = v.dec ? v.src - 16'(k) : v.src + 16'(k);
      d  = v.dec ? v.dst - 16'(k) : v.dst + 16'(k);
      c  = v.cnt - 16'(k);
      lr = v.dec ? v.src - 16'(k - 1) : v.src + 16'(k - 1);
      n  = mem_byte(lr) + v.acc;
      f  = (v.fl & 8'hC1) | {2'b00, n[1], 1'b0, n[3], (c != 16'd0), 2'b00};
      cyc = v.rep ? (32'(k) * 32'd16 + 32'(k - 1) * 32'd5) : 32'd16;
      check("R1 write errors", 32'(n_wrerr), 32'd0);
      check("R2 src_out", {16'd0, src_out}, {16'd0, s});
      check("R2 dst_out", {16'd0, dst_out}, {16'd0, d});
      check("R3 cnt_out", {16'd0, cnt_out}, {16'd0, c});
      check("R4 kept and cleared bits", {24'd0, flags_out & 8'hD3}, {24'd0, f & 8'hD3});
      check("R5 pv bit", {31'd0, flags_out[2]}, {31'd0, f[2]});
      check("R6 undoc bits", {24'd0, flags_out & 8'h28}, {24'd0, f & 8'h28});
      check(v.rep ? "R8 cycles" : "R7 cycles", cycles_out, cyc);
      check(v.rep ? "R8 iterations" : "R7 iterations", 32'(n_wr), 32'(k));
      @(negedge clk);
      check("R9 done width", {31'd0, done}, 32'd0);
      check("R9 outputs hold", {16'd0, src_out}, {16'd0, s});
   endtask

   initial begin
      bit   ok;
      vec_t v;
      repeat (3) @(negedge clk);
      check("R9 reset busy", {31'd0, busy}, 32'd0);
      check("R9 reset done", {31'd0, done}, 32'd0);
      check("R1 reset mem_re", {31'd0, mem_re}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 reset cycles", cycles_out, 32'd0);

      for (int i = 0; i < NV; i++) begin
         launch(VECS[i]);
         check("R9 busy after start", {31'd0, busy}, 32'd1);
         wait_done(ok);
         if (ok) expect_result(VECS[i]);
      end

      // R10: start while busy with other operands must not disturb the run
      v = '{1'b1, 1'b0, 16'h0100, 16'h0200, 16'h0003, 8'h31, 8'h40};
      launch(v);
      @(negedge clk);
      src_in = 16'h7777; cnt_in = 16'h0009; acc_in = 8'hEE; dec_mode = 1'b1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(ok);
      if (ok) begin
         check("R10 ignored start cnt", {16'd0, cnt_out}, 32'd0);
         expect_result(v);
      end

      // R3 R8: zero count in repeat mode sweeps all 64 KiB
      v = '{1'b1, 1'b0, 16'hFFF0, 16'h8000, 16'h0000, 8'h02, 8'h00};
      launch(v);
      wait_done(ok);
      if (ok) expect_result(v);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule